// File: doc/BRIEF.md
# Selectable-Sense Parity Generator and Checker

This block produces a parity bit for an outgoing data word and judges an incoming data word against its received parity bit. One sense input selects even or odd parity and applies to both halves at once. The generator reduces the data through a balanced tree of two-input XOR stages and then optionally inverts the result. The checker rebuilds the parity of the received word with the same tree and XORs it with the received parity bit. Its output means "error detected" in both senses.

Both outputs are registered, so each result appears one clock after the inputs that produced it. A synchronous, active-high reset clears both outputs. The data width is a parameter. Odd widths are handled by passing the unpaired bit of a tree stage on to the next stage.

Parity detects any odd number of flipped bits and misses any even number. It cannot locate the flipped bit: a corrupted data bit and a corrupted parity bit give the same indication.

Top module: `sense_parity_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `tx_par` and `rx_err` are 0 after that edge.
- R2: With `odd_sel` = 0 at a rising edge, `tx_par` after that edge makes the total count of ones in {`tx_par`, `tx_data`} even.
- R3: With `odd_sel` = 1 at a rising edge, `tx_par` after that edge makes the total count of ones in {`tx_par`, `tx_data`} odd. A change of `odd_sel` alone flips `tx_par` one cycle later.
- R4: `rx_err` after an edge is 1 exactly when the count of ones in {`rx_par`, `rx_data`} sampled at that edge does not match the selected sense (even for `odd_sel` = 0, odd for `odd_sel` = 1). In both senses, 1 means an error was detected and 0 means none.
- R5: A received word equal to the transmitted word, with the parity bit the generator produced for it under the same sense, gives `rx_err` = 0.
- R6: Flipping exactly one data bit of a consistent word gives `rx_err` = 1, for every bit position.
- R7: Flipping only the parity bit of a consistent word gives `rx_err` = 1, the same indication as a flipped data bit.
- R8: Flipping exactly two bits of a consistent word (two data bits, or one data bit and the parity bit) gives `rx_err` = 0.
- R9: Results are correct for odd data widths as well, such as `W` = 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| odd_sel | input | 1 | Parity sense: 0 = even, 1 = odd |
| tx_data | input | W | Data word to generate parity for |
| tx_par | output | 1 | Registered generated parity bit |
| rx_data | input | W | Received data word |
| rx_par | input | 1 | Received parity bit |
| rx_err | output | 1 | Registered error flag: 1 = parity mismatch detected |

## Verification
The only state in this block is the pair of output registers. A faulty tree node or a missing sense inversion therefore shows up as a wrong `tx_par` or `rx_err` one cycle after a word that exercises that node. An exhaustive walk over all data words in both senses exposes every such fault within that many cycles. Feeding each generated bit back into the checker and then flipping one and two bits confirms two things: that both halves agree on the same tree, and that the error coding does not depend on the sense.

// File: rtl/parity_pkg.sv
package parity_pkg;

  typedef enum logic {
    SENSE_EVEN = 1'b0,
    SENSE_ODD  = 1'b1
  } sense_e;

  // Number of nodes remaining after k pairing stages of a w-bit tree
  function automatic int stage_width(input int w, input int k);
    return (w + (1 << k) - 1) >> k;
  endfunction

  // Stages needed to reduce w bits to one
  function automatic int tree_levels(input int w);
    int n;
    int lv;
    n  = w;
    lv = 0;
    while (n > 1) begin
      n  = (n + 1) / 2;
      lv = lv + 1;
    end
    return lv;
  endfunction

endpackage

// File: rtl/parity_xor_tree.sv
module parity_xor_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits,
  output logic         red
);
  localparam int LV = parity_pkg::tree_levels(W);

  generate
    if (LV == 0) begin : g_single
      assign red = bits[0];
    end else begin : g_tree
      for (genvar k = 0; k < LV; k++) begin : g_lvl
        localparam int CUR = parity_pkg::stage_width(W, k);
        localparam int NXT = parity_pkg::stage_width(W, k + 1);
        logic [CUR-1:0] src;
        logic [NXT-1:0] nodes;
        if (k == 0) begin : g_from_in
          assign src = bits;
        end else begin : g_from_prev
          assign src = g_lvl[k-1].nodes;
        end
        for (genvar i = 0; i < NXT; i++) begin : g_node
          if (2 * i + 1 < CUR) begin : g_pair
            assign nodes[i] = src[2*i] ^ src[2*i+1];
          end else begin : g_pass
            assign nodes[i] = src[2*i];
          end
        end
      end
      assign red = g_lvl[LV-1].nodes[0];
    end
  endgenerate
endmodule

// File: rtl/parity_gen.sv
module parity_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic         odd_sel,
  output logic         par
);
  logic tree_out;

  parity_xor_tree #(.W(W)) u_tree (
    .bits (data),
    .red  (tree_out)
  );

  // Programmable inverter: even bit passes, odd sense complements it
  assign par = tree_out ^ (odd_sel == parity_pkg::SENSE_ODD);
endmodule

// File: rtl/parity_chk.sv
module parity_chk #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic         par_in,
  input  logic         odd_sel,
  output logic         err
);
  logic local_par;

  parity_gen #(.W(W)) u_regen (
    .data    (data),
    .odd_sel (odd_sel),
    .par     (local_par)
  );

  // Comparison stays an XOR in both senses: 1 always means mismatch
  assign err = local_par ^ par_in;
endmodule

// File: rtl/sense_parity_unit.sv
module sense_parity_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         odd_sel,
  input  logic [W-1:0] tx_data,
  output logic         tx_par,
  input  logic [W-1:0] rx_data,
  input  logic         rx_par,
  output logic         rx_err
);
  logic gen_par;
  logic chk_err;

  parity_gen #(.W(W)) u_gen (
    .data    (tx_data),
    .odd_sel (odd_sel),
    .par     (gen_par)
  );

  parity_chk #(.W(W)) u_chk_path (
    .data    (rx_data),
    .par_in  (rx_par),
    .odd_sel (odd_sel),
    .err     (chk_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_par <= 1'b0;
      rx_err <= 1'b0;
    end else begin
      tx_par <= gen_par;
      rx_err <= chk_err;
    end
  end
endmodule

// File: rtl/sense_parity_unit_chk.sv
module sense_parity_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         odd_sel,
  input logic [W-1:0] tx_data,
  input logic         tx_par,
  input logic [W-1:0] rx_data,
  input logic         rx_par,
  input logic         rx_err
);
  // Set once the previous edge was outside reset
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (tx_par == 1'b0 && rx_err == 1'b0));

  assert_gen_sense_R2: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((($countones($past(tx_data)) + int'(tx_par)) % 2) == int'($past(odd_sel))));

  assert_chk_code_R4: assert property (@(posedge clk) disable iff (rst)
    armed |-> (rx_err == ((($countones($past(rx_data)) + int'($past(rx_par))) % 2) != int'($past(odd_sel)))));

  assert_loopback_clean_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(rx_data) == $past(tx_data) && $past(rx_par) == tx_par) |-> !rx_err);

  assert_single_flip_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && $countones($past(rx_data ^ tx_data)) == 1 && $past(rx_par) == tx_par) |-> rx_err);

  assert_double_flip_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && $countones($past(rx_data ^ tx_data)) == 2 && $past(rx_par) == tx_par) |-> !rx_err);
endmodule

bind sense_parity_unit sense_parity_unit_chk #(.W(W)) u_props (.*);

// File: tb/sense_parity_unit_test.sv
`timescale 1ns/1ps
module sense_parity_unit_test;
  localparam int W  = 8;
  localparam int W5 = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic odd_sel = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic [W-1:0] rx_data = '0;
  logic rx_par = 1'b0;
  logic tx_par;
  logic rx_err;

  logic [W5-1:0] tx5 = '0;
  logic [W5-1:0] rx5 = '0;
  logic rx5_par = 1'b0;
  logic tx5_par;
  logic rx5_err;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sense_parity_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .odd_sel(odd_sel),
    .tx_data(tx_data), .tx_par(tx_par),
    .rx_data(rx_data), .rx_par(rx_par), .rx_err(rx_err)
  );

  sense_parity_unit #(.W(W5)) uut5 (
    .clk(clk), .rst(rst), .odd_sel(odd_sel),
    .tx_data(tx5), .tx_par(tx5_par),
    .rx_data(rx5), .rx_par(rx5_par), .rx_err(rx5_err)
  );

  // {odd_sel, data, expected parity} worked out by hand
  localparam logic [9:0] VEC [0:7] = '{
    {1'b0, 8'h00, 1'b0},
    {1'b1, 8'h00, 1'b1},
    {1'b0, 8'hFF, 1'b0},
    {1'b0, 8'h01, 1'b1},
    {1'b0, 8'hA5, 1'b0},
    {1'b1, 8'h07, 1'b0},
    {1'b1, 8'h80, 1'b0},
    {1'b1, 8'h3C, 1'b1}
  };

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  // Bit that makes the ones count match the sense
  function automatic logic want_par(input logic [W-1:0] v, input logic sense);
    return logic'((ones(v) + int'(sense)) % 2);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (sense=%0b tx=%h rx=%h rxp=%0b)",
               req, act, exp, odd_sel, tx_data, rx_data, rx_par);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic p;
    rx_par = 1'b1;
    rx_data = 8'h01;
    tx_data = 8'h01;
    step();
    step();
    check("R1 tx_par in reset", tx_par, 1'b0);
    check("R1 rx_err in reset", rx_err, 1'b0);
    rst = 1'b0;

    // Table walk
    for (int k = 0; k < 8; k++) begin
      odd_sel = VEC[k][9];
      tx_data = VEC[k][8:1];
      rx_data = VEC[k][8:1];
      rx_par  = VEC[k][0];
      step();
      check(VEC[k][9] ? "R3 table parity" : "R2 table parity", tx_par, VEC[k][0]);
      check("R5 table loopback", rx_err, 1'b0);
    end

    // Sense change alone flips the bit
    tx_data = 8'h5A;
    odd_sel = 1'b0;
    step();
    check("R2 sense even 5A", tx_par, 1'b0);
    odd_sel = 1'b1;
    step();
    check("R3 sense switch 5A", tx_par, 1'b1);

    // Exhaustive walk with flips
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 256; d++) begin
        odd_sel = logic'(s);
        tx_data = 8'(d);
        p = want_par(8'(d), logic'(s));
        rx_data = 8'(d);
        rx_par  = p;
        step();
        check(s ? "R3 gen" : "R2 gen", tx_par, p);
        check("R5 loopback", rx_err, 1'b0);
        for (int b = 0; b < W; b++) begin
          rx_data = 8'(d) ^ (8'h01 << b);
          rx_par  = p;
          step();
          check("R6 single data flip", rx_err, 1'b1);
        end
        rx_data = 8'(d);
        rx_par  = ~p;
        step();
        check("R7 parity flip", rx_err, 1'b1);
        rx_data = 8'(d) ^ 8'h81;
        rx_par  = p;
        step();
        check("R8 two data flips", rx_err, 1'b0);
        rx_data = 8'(d) ^ 8'h10;
        rx_par  = ~p;
        step();
        check("R8 data plus parity flip", rx_err, 1'b0);
        rx_data = 8'(d) ^ 8'h07;
        rx_par  = p;
        step();
        check("R4 triple flip detected", rx_err, 1'b1);
      end
    end

    // Odd width instance
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 32; d++) begin
        odd_sel = logic'(s);
        tx5 = 5'(d);
        p = want_par(8'(d), logic'(s));
        rx5 = 5'(d) ^ 5'h10;
        rx5_par = p;
        step();
        check("R9 width5 gen", tx5_par, p);
        check("R9 width5 top bit flip", rx5_err, 1'b1);
      end
    end

    // Reset mid-stream clears outputs
    odd_sel = 1'b1;
    tx_data = 8'h00;
    rx_data = 8'h00;
    rx_par  = 1'b0;
    step();
    check("R4 odd sense mismatch", rx_err, 1'b1);
    rst = 1'b1;
    step();
    check("R1 reset tx_par", tx_par, 1'b0);
    check("R1 reset rx_err", rx_err, 1'b0);
    rst = 1'b0;
    step();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule